// File: doc/BRIEF.md
# I2C Master SCL Timing Generator

This block produces the serial clock of an I2C master from a faster peripheral clock. Software programs a 12-bit divider, a standard/fast selector, a duty selector and a rise-time allowance. It also programs the peripheral clock frequency in MHz, which the block checks for range. While enabled, the block alternates between a low phase, in which it pulls SCL down, and a released phase, in which the open-drain line is left to the pull-up. At the last cycle of each phase it gives the bit engine a one-cycle strobe, so the engine can shift data and generate START/STOP conditions.

The released phase is measured against the SCL level that is sampled back from the bus. The high-phase count begins when SCL is first seen high. Cycles spent waiting for the edge are credited against the high phase, up to the programmed allowance. A slow pull-up within the allowance therefore leaves the bus period unchanged. A slave that holds SCL low for longer than the allowance stretches the period by the excess. Configuration is copied into shadow registers only while the generator is disabled, so a running clock never sees a half-written setting.

Top module: `scl_clkgen`

## Requirements
- R1: Standard mode (`fast_sel`=0): the low phase lasts B cycles and the nominal high length H is B cycles, where B = max(`divider`, 4). `duty_sel` has no effect in this mode.
- R2: Fast mode with `fast_sel`=1, `duty_sel`=0 (2:1): the low phase lasts 2·B cycles and H = B, where B = max(`divider`, 1).
- R3: Fast mode with `fast_sel`=1, `duty_sel`=1 (16:9): the low phase lasts 16·B cycles and H = 9·B, where B = max(`divider`, 1).
- R4: Divider values below the mode minimum are raised to it: to 4 in standard mode and to 1 (from 0) in either fast mode.
- R5: The released phase is the time from `scl_pull_low` falling to its next rise. Let k be the number of released cycles in which `scl_in` is sampled low before it is first sampled high. If k ≤ `rise_clks`, the released phase lasts max(k+2, H) cycles.
- R6: If k > `rise_clks` (the slave stretches the clock), the released phase lasts k + 1 + max(1, H − 1 − `rise_clks`) cycles, and SCL is never pulled low while `scl_in` is still low in that phase.
- R7: `low_strobe` is high for exactly one cycle per low phase, in its last cycle. `high_strobe` is high for exactly one cycle per released phase, in its last cycle.
- R8: While `enable` is 0 or `rst` is 1, `scl_pull_low` and both strobes are 0. The low phase begins in the cycle after `enable` is first sampled 1, with a full low length, also after a disable in mid-period.
- R9: A `freq_mhz` value outside 2..36 sets `cfg_err` while `enable` is 1, and the generator then stays released. Values 2 and 36 are accepted.
- R10: The divider, selectors, rise allowance and frequency are taken only while the generator is idle. Changes made while it runs have no effect on the phase lengths or on `cfg_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the generator; 0 releases SCL and clears the counters |
| freq_mhz | input | 6 | Peripheral clock frequency in MHz (range checked) |
| divider | input | 12 | Base divider B before minimum clamping |
| fast_sel | input | 1 | 0 = standard mode, 1 = fast mode |
| duty_sel | input | 1 | Fast-mode ratio: 0 = 2:1, 1 = 16:9 |
| rise_clks | input | 6 | Rise-time allowance in peripheral clocks |
| scl_in | input | 1 | SCL level sampled from the bus (already synchronised) |
| scl_pull_low | output | 1 | 1 = drive SCL to 0, 0 = release (high-Z) |
| low_strobe | output | 1 | One-cycle pulse in the last low-phase cycle |
| high_strobe | output | 1 | One-cycle pulse in the last released-phase cycle |
| cfg_err | output | 1 | Frequency field out of range while enabled |

## Verification
`scl_pull_low` and the strobes are decoded from the phase register. They change one cycle after the edge that moves the phase, and `scl_pull_low` first rises one cycle after `enable` is sampled. The bench therefore samples at the falling clock edge and counts phase lengths in whole cycles between transitions of `scl_pull_low`. The bench models the bus as an open-drain line whose rising edge takes a chosen number of cycles, so k is known in advance and the released length follows from the R5/R6 formulas. `cfg_err` comes from a shadow register filled while the generator is idle, so it is checked two cycles after the frequency and enable settle.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_LOW  = 2'd1,
        PH_WAIT = 2'd2,
        PH_HIGH = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        RT_EVEN         = 2'd0,
        RT_TWO_ONE      = 2'd1,
        RT_SIXTEEN_NINE = 2'd2
    } ratio_e;

    typedef struct packed {
        logic [4:0] lo_mult;
        logic [3:0] hi_mult;
        logic [2:0] min_div;
    } ratio_shape_t;

    function automatic ratio_e pick_ratio(input logic fast, input logic duty);
        if (!fast)     return RT_EVEN;
        else if (duty) return RT_SIXTEEN_NINE;
        else           return RT_TWO_ONE;
    endfunction

    function automatic ratio_shape_t shape_of(input ratio_e r);
        ratio_shape_t s;
        case (r)
            RT_TWO_ONE:      s = '{lo_mult: 5'd2,  hi_mult: 4'd1, min_div: 3'd1};
            RT_SIXTEEN_NINE: s = '{lo_mult: 5'd16, hi_mult: 4'd9, min_div: 3'd1};
            default:         s = '{lo_mult: 5'd1,  hi_mult: 4'd1, min_div: 3'd4};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/scl_cfg_shadow.sv
module scl_cfg_shadow
    import scl_gen_pkg::*;
#(
    parameter int DIV_W   = 12,
    parameter int FREQ_W  = 6,
    parameter int RISE_W  = 6,
    parameter int CNT_W   = DIV_W + 4,
    parameter int MIN_MHZ = 2,
    parameter int MAX_MHZ = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [FREQ_W-1:0] freq_mhz,
    input  logic [DIV_W-1:0]  divider,
    input  logic              fast_sel,
    input  logic              duty_sel,
    input  logic [RISE_W-1:0] rise_clks,
    output logic [CNT_W-1:0]  low_len,
    output logic [CNT_W-1:0]  high_len,
    output logic [RISE_W-1:0] rise_allow,
    output logic              cfg_bad
);

    logic [FREQ_W-1:0] freq_q;
    logic [DIV_W-1:0]  div_q;
    ratio_e            ratio_q;
    logic [RISE_W-1:0] rise_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            freq_q  <= '0;
            div_q   <= '0;
            ratio_q <= RT_EVEN;
            rise_q  <= '0;
        end else if (load) begin
            freq_q  <= freq_mhz;
            div_q   <= divider;
            ratio_q <= pick_ratio(fast_sel, duty_sel);
            rise_q  <= rise_clks;
        end
    end

    ratio_shape_t     shp;
    logic [DIV_W-1:0] floor_v;
    logic [DIV_W-1:0] eff_div;

    always_comb begin
        shp      = shape_of(ratio_q);
        floor_v  = DIV_W'(shp.min_div);
        eff_div  = (div_q < floor_v) ? floor_v : div_q;
        low_len  = CNT_W'(eff_div) * CNT_W'(shp.lo_mult);
        high_len = CNT_W'(eff_div) * CNT_W'(shp.hi_mult);
    end

    assign rise_allow = rise_q;
    assign cfg_bad    = (freq_q < FREQ_W'(MIN_MHZ)) || (freq_q > FREQ_W'(MAX_MHZ));

    // settings stay frozen while the generator runs
    p_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        (!load && $past(!load)) |-> ($stable(low_len) && $stable(high_len) && $stable(rise_allow)));

    p_lengths_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
        !load |-> (low_len != '0 && high_len != '0));

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_gen_pkg::*;
#(
    parameter int RISE_W = 6,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              cfg_bad,
    input  logic              scl_in,
    input  logic [CNT_W-1:0]  low_len,
    input  logic [CNT_W-1:0]  high_len,
    input  logic [RISE_W-1:0] rise_allow,
    output logic              pull_low,
    output logic              low_strb,
    output logic              high_strb,
    output logic              idle
);

    phase_e           state, nxt_state;
    logic [CNT_W-1:0] cnt, nxt_cnt;

    logic [CNT_W-1:0] rise_w;
    logic [CNT_W-1:0] credit;
    logic [CNT_W-1:0] hi_last;
    logic [CNT_W-1:0] hi_start;
    logic             low_end;
    logic             high_end;

    always_comb begin
        rise_w   = CNT_W'(rise_allow);
        credit   = ((cnt < rise_w) ? cnt : rise_w) + CNT_W'(1);
        hi_last  = high_len - CNT_W'(1);
        hi_start = (credit > hi_last) ? hi_last : credit;
        low_end  = (cnt >= low_len - CNT_W'(1));
        high_end = (cnt >= hi_last);
    end

    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        unique case (state)
            PH_OFF: begin
                nxt_cnt = '0;
                if (!cfg_bad) nxt_state = PH_LOW;
            end
            PH_LOW: begin
                if (low_end) begin
                    nxt_state = PH_WAIT;
                    nxt_cnt   = '0;
                end else begin
                    nxt_cnt = cnt + CNT_W'(1);
                end
            end
            PH_WAIT: begin
                if (scl_in) begin
                    nxt_state = PH_HIGH;
                    nxt_cnt   = hi_start;
                end else if (cnt != '1) begin
                    nxt_cnt = cnt + CNT_W'(1);
                end
            end
            PH_HIGH: begin
                if (high_end) begin
                    nxt_state = PH_LOW;
                    nxt_cnt   = '0;
                end else begin
                    nxt_cnt = cnt + CNT_W'(1);
                end
            end
            default: begin
                nxt_state = PH_OFF;
                nxt_cnt   = '0;
            end
        endcase
        if (!enable) begin
            nxt_state = PH_OFF;
            nxt_cnt   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PH_OFF;
            cnt   <= '0;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
        end
    end

    assign pull_low  = (state == PH_LOW);
    assign low_strb  = (state == PH_LOW) && low_end;
    assign high_strb = (state == PH_HIGH) && high_end;
    assign idle      = (state == PH_OFF);

    // a disabled generator lets SCL go on the next cycle
    p_off_released_r8: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !pull_low);

    // end of low phase is followed by a release
    p_low_strb_release_r7: assert property (@(posedge clk) disable iff (rst)
        (low_strb && enable) |=> !pull_low);

    // end of released phase is followed by a pull-down
    p_high_strb_pull_r7: assert property (@(posedge clk) disable iff (rst)
        (high_strb && enable) |=> pull_low);

    // a slave holding SCL low keeps the generator waiting
    p_stretch_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (enable && state == PH_WAIT && !scl_in) |=> (state == PH_WAIT));

    // a bad frequency keeps the generator idle
    p_err_blocks_r9: assert property (@(posedge clk) disable iff (rst)
        (idle && cfg_bad) |=> idle);

    p_low_bound_r1: assert property (@(posedge clk) disable iff (rst)
        (state == PH_LOW) |-> (cnt < low_len));

endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
    import scl_gen_pkg::*;
#(
    parameter int DIV_W   = 12,
    parameter int FREQ_W  = 6,
    parameter int RISE_W  = 6,
    parameter int MIN_MHZ = 2,
    parameter int MAX_MHZ = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [FREQ_W-1:0] freq_mhz,
    input  logic [DIV_W-1:0]  divider,
    input  logic              fast_sel,
    input  logic              duty_sel,
    input  logic [RISE_W-1:0] rise_clks,
    input  logic              scl_in,
    output logic              scl_pull_low,
    output logic              low_strobe,
    output logic              high_strobe,
    output logic              cfg_err
);

    localparam int CNT_W = DIV_W + 4;

    logic [CNT_W-1:0]  low_len;
    logic [CNT_W-1:0]  high_len;
    logic [RISE_W-1:0] rise_allow;
    logic              cfg_bad;
    logic              idle;

    scl_cfg_shadow #(
        .DIV_W   (DIV_W),
        .FREQ_W  (FREQ_W),
        .RISE_W  (RISE_W),
        .CNT_W   (CNT_W),
        .MIN_MHZ (MIN_MHZ),
        .MAX_MHZ (MAX_MHZ)
    ) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .load       (idle),
        .freq_mhz   (freq_mhz),
        .divider    (divider),
        .fast_sel   (fast_sel),
        .duty_sel   (duty_sel),
        .rise_clks  (rise_clks),
        .low_len    (low_len),
        .high_len   (high_len),
        .rise_allow (rise_allow),
        .cfg_bad    (cfg_bad)
    );

    scl_phase_fsm #(
        .RISE_W (RISE_W),
        .CNT_W  (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .cfg_bad    (cfg_bad),
        .scl_in     (scl_in),
        .low_len    (low_len),
        .high_len   (high_len),
        .rise_allow (rise_allow),
        .pull_low   (scl_pull_low),
        .low_strb   (low_strobe),
        .high_strb  (high_strobe),
        .idle       (idle)
    );

    assign cfg_err = enable && idle && cfg_bad;

    p_err_released_r9: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !scl_pull_low);

endmodule

// File: tb/test_scl_clkgen.sv
`timescale 1ns/1ps
module test_scl_clkgen;

    localparam int RALLOW = 3;

    logic       clk = 1'b0;
    logic       rst;
    logic       enable;
    logic [5:0] freq_mhz;
    logic [11:0] divider;
    logic       fast_sel;
    logic       duty_sel;
    logic [5:0] rise_clks;
    logic       scl_line;
    logic       scl_pull_low;
    logic       low_strobe;
    logic       high_strobe;
    logic       cfg_err;

    int n_total = 0;
    int n_fail  = 0;
    int rise_delay = 0;
    int line_ctr = 0;

    always #2.5 clk = ~clk;

    scl_clkgen i_scl_clkgen (
        .clk          (clk),
        .rst          (rst),
        .enable       (enable),
        .freq_mhz     (freq_mhz),
        .divider      (divider),
        .fast_sel     (fast_sel),
        .duty_sel     (duty_sel),
        .rise_clks    (rise_clks),
        .scl_in       (scl_line),
        .scl_pull_low (scl_pull_low),
        .low_strobe   (low_strobe),
        .high_strobe  (high_strobe),
        .cfg_err      (cfg_err)
    );

    // open-drain bus with a slow rising edge of rise_delay cycles
    always @(posedge clk) begin
        if (scl_pull_low) line_ctr <= 0;
        else if (line_ctr < 100000) line_ctr <= line_ctr + 1;
    end
    assign scl_line = !scl_pull_low && (line_ctr >= rise_delay);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int base_of(input int mode, input int dv);
        if (mode == 0) return (dv < 4) ? 4 : dv;
        return (dv < 1) ? 1 : dv;
    endfunction

    function automatic int low_of(input int mode, input int dv);
        int b = base_of(mode, dv);
        if (mode == 0) return b;
        if (mode == 1) return 2 * b;
        return 16 * b;
    endfunction

    function automatic int high_of(input int mode, input int dv);
        int b = base_of(mode, dv);
        if (mode == 2) return 9 * b;
        return b;
    endfunction

    function automatic int rel_of(input int h, input int k, input int r);
        int c  = (k < r) ? k : r;
        int hc = h - 1 - c;
        if (hc < 1) hc = 1;
        return k + 1 + hc;
    endfunction

    // measures one low phase and the following released phase
    task automatic measure(output int lo, output int rel, output bit ls_ok, output bit hs_ok);
        int guard = 0;
        int lsc = 0;
        int hsc = 0;
        bit lsl = 0;
        bit hsl = 0;
        lo = 0;
        rel = 0;
        while (!scl_pull_low && guard < 4000) begin @(negedge clk); guard++; end
        while (scl_pull_low && guard < 4000) begin
            lo++;
            lsc += int'(low_strobe);
            lsl = low_strobe;
            if (high_strobe) hsc += 100;
            @(negedge clk);
            guard++;
        end
        while (!scl_pull_low && guard < 4000) begin
            rel++;
            hsc += int'(high_strobe);
            hsl = high_strobe;
            if (low_strobe) lsc += 100;
            @(negedge clk);
            guard++;
        end
        ls_ok = (lsc == 1) && lsl;
        hs_ok = (hsc == 1) && hsl;
    endtask

    task automatic setup(input int mode, input int dv, input int dl);
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        freq_mhz   = 6'd8;
        divider    = 12'(dv);
        fast_sel   = (mode != 0);
        duty_sel   = (mode == 2) || (mode == 0 && dv[0]);
        rise_clks  = 6'(RALLOW);
        rise_delay = dl;
        @(negedge clk);
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  %0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        int lo, rel, exp_lo, exp_rel;
        bit ls_ok, hs_ok;
        int quiet;
        string lt, rt;

        rst = 1'b1; enable = 1'b1; freq_mhz = 6'd8; divider = 12'd5;
        fast_sel = 1'b0; duty_sel = 1'b0; rise_clks = 6'(RALLOW);
        repeat (4) @(negedge clk);
        // R8: reset holds the line released and strobes quiet
        chk(!scl_pull_low && !low_strobe && !high_strobe, "R8 reset state", int'(scl_pull_low), 0);
        enable = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        quiet = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            quiet += int'(scl_pull_low) + int'(low_strobe) + int'(high_strobe);
        end
        chk(quiet == 0, "R8 disabled stays released", quiet, 0);

        // R1 R2 R3 R4 R5 R6 R7: sweep of modes, dividers and edge delays
        for (int m = 0; m < 3; m++) begin
            for (int di = 0; di < 6; di++) begin
                for (int de = 0; de < 3; de++) begin
                    int dv = (di == 5) ? 6 : di;
                    int dl = (de == 0) ? 0 : ((de == 1) ? 2 : 6);
                    setup(m, dv, dl);
                    chk(scl_pull_low == 1'b1, "R8 low phase starts after enable", int'(scl_pull_low), 1);
                    measure(lo, rel, ls_ok, hs_ok);
                    exp_lo  = low_of(m, dv);
                    exp_rel = rel_of(high_of(m, dv), dl, RALLOW);
                    if (dv < base_of(m, dv)) lt = "R4 divider clamp low phase";
                    else if (m == 0) lt = "R1 standard low phase";
                    else if (m == 1) lt = "R2 fast 2:1 low phase";
                    else lt = "R3 fast 16:9 low phase";
                    rt = (dl <= RALLOW) ? "R5 released phase with rise credit"
                                        : "R6 released phase under stretch";
                    chk(lo == exp_lo, lt, lo, exp_lo);
                    chk(rel == exp_rel, rt, rel, exp_rel);
                    chk(ls_ok && hs_ok, "R7 strobe in last cycle of each phase",
                        int'(ls_ok) + 2 * int'(hs_ok), 3);
                end
            end
        end

        // R10: changes while running are ignored
        setup(0, 5, 0);
        divider = 12'd9; fast_sel = 1'b1; duty_sel = 1'b1; rise_clks = 6'd0; freq_mhz = 6'd50;
        measure(lo, rel, ls_ok, hs_ok);
        measure(lo, rel, ls_ok, hs_ok);
        chk(lo == 5, "R10 low length frozen while running", lo, 5);
        chk(rel == 5, "R10 released length frozen while running", rel, 5);
        chk(cfg_err == 1'b0, "R10 cfg_err unaffected while running", int'(cfg_err), 0);

        // R8: disable mid-period, then restart from a full low phase
        setup(1, 3, 0);
        while (scl_pull_low) @(negedge clk);
        @(negedge clk);
        enable = 1'b0;
        quiet = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            quiet += int'(scl_pull_low) + int'(low_strobe) + int'(high_strobe);
        end
        chk(quiet == 0, "R8 released after mid-period disable", quiet, 0);
        enable = 1'b1;
        @(negedge clk);
        chk(scl_pull_low == 1'b1, "R8 restart pulls low", int'(scl_pull_low), 1);
        measure(lo, rel, ls_ok, hs_ok);
        chk(lo == 6, "R8 restart full low length", lo, 6);

        // R9: frequency range checks at and beyond both limits
        for (int f = 0; f < 6; f++) begin
            int fq = (f == 0) ? 1 : (f == 1) ? 2 : (f == 2) ? 36 : (f == 3) ? 37 : (f == 4) ? 0 : 63;
            bit bad = (fq < 2) || (fq > 36);
            @(negedge clk);
            enable = 1'b0;
            @(negedge clk);
            freq_mhz = 6'(fq); divider = 12'd4; fast_sel = 1'b0; duty_sel = 1'b0;
            @(negedge clk);
            @(negedge clk);
            enable = 1'b1;
            @(negedge clk);
            @(negedge clk);
            chk(cfg_err == bad, "R9 cfg_err for frequency field", int'(cfg_err), int'(bad));
            quiet = 0;
            for (int i = 0; i < 12; i++) begin
                quiet += int'(scl_pull_low);
                @(negedge clk);
            end
            if (bad) chk(quiet == 0, "R9 generator held released", quiet, 0);
            else     chk(quiet > 0, "R9 accepted frequency runs", quiet, 1);
        end
        enable = 1'b0;
        @(negedge clk);

        $display("  %0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule